// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns an already unpacked floating-point operand into a signed two's-complement integer. The operand arrives as a class code, a sign, a signed unbiased exponent and a mantissa whose top bit is the explicit leading one. The result is always rounded toward zero, whatever rounding mode the surrounding unit selects. Besides the integer it raises an inexact flag when fraction bits were dropped and an invalid flag when the operand cannot be represented.

The path is purely combinational: result and flags are valid in the same cycle as the operand. Integer width, mantissa width and exponent width are parameters, so a 64-bit result is a parameter change. The mantissa must be at least as wide as the integer.

Top module: `f2i_trunc`

## Requirements
- R1: Class code 0 (zero) gives result 0 with both flags low, whatever sign, exponent and mantissa are applied.
- R2: Class codes are 0 zero, 1 finite number, 2 infinity, 3 quiet NaN, 4 signalling NaN; codes 2, 3, 4 and the unused codes 5 to 7 take the overflow path of R8.
- R3: A finite number whose exponent is INT_W or larger takes the overflow path of R8.
- R4: Otherwise the operand value is mant × 2^(exp − (MANT_W−1)); the result is the integer part of its magnitude, negated in two's complement when the sign is 1.
- R5: For an in-range finite number the inexact flag is 1 exactly when a mantissa bit below the integer part is 1; invalid stays 0.
- R6: A finite number with a negative exponent, however large in magnitude, gives result 0 with inexact set (the mantissa has its leading one).
- R7: The range limit depends on the sign: a magnitude of 2^(INT_W−1) is accepted for a negative operand (result 1 followed by zeros) but overflows for a positive one.
- R8: On overflow invalid is 1, inexact is 0, and the result is 2^(INT_W−1)−1 for sign 0 or 2^(INT_W−1) (bit pattern 1 followed by zeros) for sign 1.
- R9: The rounding-mode input has no effect on result or flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cls_i | input | 3 | Operand class code (see R2) |
| sign_i | input | 1 | Operand sign, 1 = negative |
| exp_i | input | EXP_W | Signed unbiased exponent |
| mant_i | input | MANT_W | Mantissa, top bit is the leading one |
| rmode_i | input | 2 | Rounding mode of the unit, ignored |
| result_o | output | INT_W | Truncated two's-complement integer |
| inexact_o | output | 1 | Fraction bits were discarded |
| invalid_o | output | 1 | Operand not representable; result saturated |

## Verification
The hardest corner to reach from the ports is the sign-dependent edge of the range, where a magnitude of exactly 2^(INT_W−1) must pass for a negative operand and fail for a positive one, together with fraction bits lying just below or far below the integer point. The bench reaches it by sweeping every mantissa with its leading one, both signs and every exponent of a narrow configuration (8-bit integer, 8-bit mantissa, 6-bit exponent), so each threshold, each shift amount including the saturated ones and each sticky pattern is visited. A full-width instance adds directed operands at the same edges and repeats one inexact operand under all four rounding modes.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } f2i_cls_e;

  function automatic logic cls_is_zero(input logic [2:0] c);
    return c == CLS_ZERO;
  endfunction

  function automatic logic cls_is_num(input logic [2:0] c);
    return c == CLS_NUM;
  endfunction

endpackage

// File: rtl/f2i_align.sv
// Moves the integer part of the mantissa into the low bits and collects
// every bit that falls off into a sticky flag.
module f2i_align #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 64,
  parameter int EXP_W  = 10
) (
  input  logic [MANT_W-1:0]       mant_i,
  input  logic signed [EXP_W-1:0] exp_i,
  output logic [MANT_W-1:0]       mag_o,
  output logic                    sticky_o,
  output logic                    big_exp_o
);

  localparam int SH_W = $clog2(MANT_W + 1);
  localparam int DW   = ((EXP_W > SH_W) ? EXP_W : SH_W) + 2;

  // Distance from the leading-one position to the binary point,
  // clamped to [0, MANT_W] so any huge right shift empties the word.
  function automatic logic [SH_W-1:0] shift_amount(input logic signed [EXP_W-1:0] e);
    logic signed [DW-1:0] d;
    d = DW'(MANT_W - 1) - DW'(e);
    if (d < 0)
      return '0;
    else if (d > DW'(MANT_W))
      return SH_W'(MANT_W);
    else
      return d[SH_W-1:0];
  endfunction

  function automatic logic [MANT_W-1:0] lost_mask(input logic [SH_W-1:0] sh);
    return ~({MANT_W{1'b1}} << sh);
  endfunction

  logic [SH_W-1:0]      sh_w;
  logic signed [DW-1:0] exp_x;

  always_comb begin
    sh_w      = shift_amount(exp_i);
    exp_x     = DW'(exp_i);
    mag_o     = mant_i >> sh_w;
    sticky_o  = |(mant_i & lost_mask(sh_w));
    big_exp_o = exp_x >= DW'(INT_W);
  end

endmodule

// File: rtl/f2i_limit.sv
// Decides whether the aligned magnitude fits the signed result range.
module f2i_limit #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 64
) (
  input  logic [MANT_W-1:0] mag_i,
  input  logic              sign_i,
  output logic [INT_W-1:0]  low_o,
  output logic              too_big_o
);

  function automatic logic over_limit(input logic [INT_W-1:0] m, input logic s);
    logic [INT_W:0] lim;
    lim = {2'b01, {(INT_W-1){1'b0}}} + (INT_W+1)'(s);
    return {1'b0, m} >= lim;
  endfunction

  logic hi_any;

  generate
    if (MANT_W < INT_W) begin : g_bad_cfg
      $error("f2i_limit: MANT_W must be at least INT_W");
    end
    if (MANT_W > INT_W) begin : g_hi
      assign hi_any = |mag_i[MANT_W-1:INT_W];
    end else begin : g_no_hi
      assign hi_any = 1'b0;
    end
  endgenerate

  assign low_o     = mag_i[INT_W-1:0];
  assign too_big_o = hi_any | over_limit(mag_i[INT_W-1:0], sign_i);

endmodule

// File: rtl/f2i_pack.sv
// Selects between zero, the signed in-range value and the saturated value,
// and forms the two flags.
module f2i_pack
  import f2i_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [2:0]       cls_i,
  input  logic             sign_i,
  input  logic [INT_W-1:0] low_i,
  input  logic             sticky_i,
  input  logic             big_exp_i,
  input  logic             too_big_i,
  output logic [INT_W-1:0] result_o,
  output logic             inexact_o,
  output logic             invalid_o,
  output logic             take_num_o,
  output logic             take_ovf_o
);

  function automatic logic [INT_W-1:0] saturate(input logic s);
    return s ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
  endfunction

  function automatic logic [INT_W-1:0] apply_sign(input logic [INT_W-1:0] m, input logic s);
    return s ? (~m + INT_W'(1)) : m;
  endfunction

  always_comb begin
    take_num_o = cls_is_num(cls_i) & ~big_exp_i & ~too_big_i;
    take_ovf_o = ~cls_is_zero(cls_i) & ~take_num_o;
    if (take_ovf_o)
      result_o = saturate(sign_i);
    else if (take_num_o)
      result_o = apply_sign(low_i, sign_i);
    else
      result_o = '0;
    inexact_o = take_num_o & sticky_i;
    invalid_o = take_ovf_o;
  end

endmodule

// File: rtl/f2i_trunc.sv
module f2i_trunc #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 64,
  parameter int EXP_W  = 10
) (
  input  logic [2:0]        cls_i,
  input  logic              sign_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [1:0]        rmode_i,
  output logic [INT_W-1:0]  result_o,
  output logic              inexact_o,
  output logic              invalid_o
);

  logic [MANT_W-1:0] mag_w;
  logic              sticky_w;
  logic              big_exp_w;
  logic [INT_W-1:0]  low_w;
  logic              too_big_w;
  logic              take_num_w;
  logic              take_ovf_w;
  logic              unused_rmode;

  // Truncation is fixed; the unit's rounding mode is deliberately dropped.
  assign unused_rmode = ^rmode_i;

  f2i_align #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
    .mant_i    (mant_i),
    .exp_i     ($signed(exp_i)),
    .mag_o     (mag_w),
    .sticky_o  (sticky_w),
    .big_exp_o (big_exp_w)
  );

  f2i_limit #(.INT_W(INT_W), .MANT_W(MANT_W)) u_limit (
    .mag_i     (mag_w),
    .sign_i    (sign_i),
    .low_o     (low_w),
    .too_big_o (too_big_w)
  );

  f2i_pack #(.INT_W(INT_W)) u_pack (
    .cls_i      (cls_i),
    .sign_i     (sign_i),
    .low_i      (low_w),
    .sticky_i   (sticky_w),
    .big_exp_i  (big_exp_w),
    .too_big_i  (too_big_w),
    .result_o   (result_o),
    .inexact_o  (inexact_o),
    .invalid_o  (invalid_o),
    .take_num_o (take_num_w),
    .take_ovf_o (take_ovf_w)
  );

endmodule

// File: rtl/f2i_trunc_chk.sv
module f2i_trunc_chk #(
  parameter int INT_W = 32
) (
  input logic [2:0]       cls_i,
  input logic             sign_i,
  input logic [INT_W-1:0] result_o,
  input logic             inexact_o,
  input logic             invalid_o,
  input logic             take_num_w,
  input logic             take_ovf_w,
  input logic             big_exp_w
);

  logic [INT_W-1:0] sat_pos;
  logic [INT_W-1:0] sat_neg;
  assign sat_pos = {1'b0, {(INT_W-1){1'b1}}};
  assign sat_neg = {1'b1, {(INT_W-1){1'b0}}};

  always_comb begin
    p_zero_quiet_r1: assert (cls_i != 3'd0 || (result_o == '0 && !inexact_o && !invalid_o))
      else $error("R1: zero class produced nonzero output or flag");
    p_special_invalid_r2: assert (!(cls_i inside {3'd2, 3'd3, 3'd4}) || invalid_o)
      else $error("R2: special class without invalid");
    p_big_exp_ovf_r3: assert (!(cls_i == 3'd1 && big_exp_w) || invalid_o)
      else $error("R3: large exponent not treated as overflow");
    p_sign_r4: assert (!take_num_w || (sign_i ? (result_o == '0 || result_o[INT_W-1]) : !result_o[INT_W-1]))
      else $error("R4: in-range result has the wrong sign");
    p_inexact_src_r5: assert (!inexact_o || (cls_i == 3'd1 && !invalid_o))
      else $error("R5: inexact outside an in-range number");
    p_ovf_value_r8: assert (!invalid_o || (!inexact_o && result_o == (sign_i ? sat_neg : sat_pos)))
      else $error("R8: overflow result or flags wrong");
    p_one_path_r8: assert ($onehot0({take_num_w, take_ovf_w}))
      else $error("R8: both result paths selected");
  end

endmodule

bind f2i_trunc f2i_trunc_chk #(.INT_W(INT_W)) u_chk (
  .cls_i      (cls_i),
  .sign_i     (sign_i),
  .result_o   (result_o),
  .inexact_o  (inexact_o),
  .invalid_o  (invalid_o),
  .take_num_w (take_num_w),
  .take_ovf_w (take_ovf_w),
  .big_exp_w  (big_exp_w)
);

// File: tb/f2i_trunc_bench.sv
module f2i_trunc_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2ns clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // full-width instance
  logic [2:0]  d_cls = 3'd0;
  logic        d_sign = 1'b0;
  logic [9:0]  d_exp = '0;
  logic [63:0] d_mant = '0;
  logic [1:0]  d_rm = '0;
  logic [31:0] d_res;
  logic        d_nx, d_nv;

  f2i_trunc u_f2i_trunc (
    .cls_i(d_cls), .sign_i(d_sign), .exp_i(d_exp), .mant_i(d_mant),
    .rmode_i(d_rm), .result_o(d_res), .inexact_o(d_nx), .invalid_o(d_nv)
  );

  // narrow instance for exhaustive sweeps
  logic [2:0] s_cls = 3'd0;
  logic       s_sign = 1'b0;
  logic [5:0] s_exp = '0;
  logic [7:0] s_mant = '0;
  logic [1:0] s_rm = '0;
  logic [7:0] s_res;
  logic       s_nx, s_nv;

  f2i_trunc #(.INT_W(8), .MANT_W(8), .EXP_W(6)) u_small (
    .cls_i(s_cls), .sign_i(s_sign), .exp_i(s_exp), .mant_i(s_mant),
    .rmode_i(s_rm), .result_o(s_res), .inexact_o(s_nx), .invalid_o(s_nv)
  );

  // Arithmetic model: value = m * 2^(e-(mw-1)), truncated toward zero.
  function automatic void ref_conv(input int iw, input int mw, input logic [2:0] c,
                                   input logic s, input int e, input logic [63:0] m,
                                   output logic [31:0] r, output logic nx, output logic nv);
    longint unsigned mag, p, lim, modulus;
    bit lost;
    int sh;
    r = '0; nx = 1'b0; nv = 1'b0;
    if (c == 3'd0) return;
    if (c == 3'd1 && e < iw) begin
      sh = mw - 1 - e;
      if (sh >= 64) begin
        mag = 0; lost = (m != 0);
      end else begin
        p = 64'd1 << sh;
        mag = m / p;
        lost = (m % p) != 0;
      end
      lim = (64'd1 << (iw - 1)) + longint'(s);
      if (mag < lim) begin
        modulus = 64'd1 << iw;
        nx = lost;
        r = s ? 32'((modulus - mag) % modulus) : 32'(mag);
        return;
      end
    end
    nv = 1'b1;
    r = s ? 32'(64'd1 << (iw - 1)) : 32'((64'd1 << (iw - 1)) - 1);
  endfunction

  task automatic chk(input string tag, input logic [33:0] got, input logic [33:0] exp_v);
    n_chk++;
    if (got !== exp_v) begin
      n_err++;
      $display("FAIL %s: got res/nx/nv %h expected %h", tag, got, exp_v);
    end
  endtask

  task automatic run_big(input string tag, input logic [2:0] c, input logic s,
                         input int e, input logic [63:0] m, input logic [1:0] rm);
    logic [31:0] r; logic nx, nv;
    @(negedge clk);
    d_cls = c; d_sign = s; d_exp = 10'(e); d_mant = m; d_rm = rm;
    #1ns;
    ref_conv(32, 64, c, s, e, m, r, nx, nv);
    chk(tag, {d_res, d_nx, d_nv}, {r, nx, nv});
  endtask

  task automatic run_small(input logic [2:0] c, input logic s, input int e,
                           input logic [7:0] m, input logic [1:0] rm);
    logic [31:0] r; logic nx, nv;
    string tag;
    ref_conv(8, 8, c, s, e, {56'd0, m}, r, nx, nv);
    if (c == 3'd0)      tag = "R1";
    else if (c != 3'd1) tag = "R2";
    else if (e >= 8)    tag = "R3";
    else if (e < 0)     tag = "R6";
    else if (e == 7)    tag = "R7";
    else if (nx)        tag = "R5";
    else                tag = "R4";
    @(negedge clk);
    s_cls = c; s_sign = s; s_exp = 6'(e); s_mant = m; s_rm = rm;
    #1ns;
    chk(tag, {24'd0, s_res, s_nx, s_nv}, {r[31:0] & 32'hFF, nx, nv});
  endtask

  initial begin
    logic [33:0] first;
    repeat (4) @(posedge clk);
    rst_n = 1'b1;
    // idle state: zero class on both instances (R1)
    @(negedge clk); #1ns;
    chk("R1 idle", {d_res, d_nx, d_nv}, 34'd0);
    chk("R1 idle small", {24'd0, s_res, s_nx, s_nv}, 34'd0);

    // directed full-width operands
    run_big("R1", 3'd0, 1'b1, 17, 64'hDEAD_BEEF_0000_0001, 2'd0);
    run_big("R4", 3'd1, 1'b0, 0, 64'h8000_0000_0000_0000, 2'd0);
    run_big("R5", 3'd1, 1'b1, 1, 64'hA000_0000_0000_0000, 2'd0);
    run_big("R5", 3'd1, 1'b0, 30, 64'hFFFF_FFFF_0000_0001, 2'd0);
    run_big("R7", 3'd1, 1'b1, 31, 64'h8000_0000_0000_0000, 2'd0);
    run_big("R7", 3'd1, 1'b0, 31, 64'h8000_0000_0000_0000, 2'd0);
    run_big("R7", 3'd1, 1'b1, 31, 64'h8000_0000_0000_0001, 2'd0);
    run_big("R6", 3'd1, 1'b0, -1, 64'hC000_0000_0000_0000, 2'd0);
    run_big("R6", 3'd1, 1'b1, -500, 64'h8000_0000_0000_0000, 2'd0);
    run_big("R3", 3'd1, 1'b0, 32, 64'h8000_0000_0000_0000, 2'd0);
    run_big("R3", 3'd1, 1'b1, 300, 64'hFFFF_0000_0000_0000, 2'd0);
    run_big("R2", 3'd2, 1'b1, 0, 64'h0, 2'd0);
    run_big("R2", 3'd3, 1'b0, 0, 64'hC000_0000_0000_0000, 2'd0);
    run_big("R2", 3'd4, 1'b1, 0, 64'hA000_0000_0000_0000, 2'd0);
    run_big("R2", 3'd6, 1'b0, 3, 64'h8000_0000_0000_0000, 2'd0);

    // R9: one inexact operand under every rounding mode, same output each time
    for (int rm = 0; rm < 4; rm++) begin
      run_big("R9", 3'd1, 1'b1, 4, 64'hB800_0000_0000_0001, 2'(rm));
      if (rm == 0) first = {d_res, d_nx, d_nv};
      else chk("R9 mode-independent", {d_res, d_nx, d_nv}, first);
    end

    // exhaustive narrow sweep of finite numbers, rounding mode varied (R9)
    for (int s = 0; s < 2; s++)
      for (int e = -32; e < 32; e++)
        for (int m = 128; m < 256; m++)
          run_small(3'd1, 1'(s), e, 8'(m), 2'((e ^ m) & 3));

    // every other class code, both signs, several exponents
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 2; s++)
        for (int e = -4; e < 12; e += 3)
          if (c != 1) run_small(3'(c), 1'(s), e, 8'hC5, 2'(c & 3));

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #600us;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule